// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a parameterizable register with four operating modes, chosen on every rising clock edge by a 2-bit mode input. In one mode it captures a whole parallel word. In two others it moves its contents one position toward the most significant end or toward the least significant end. In those two shift modes, the vacated end bit is filled from a dedicated serial input. The fourth mode keeps the stored value as it is.

The mode encoding is fixed: `00` loads, `01` shifts up, `10` shifts down and `11` holds. This differs from the common arrangement in which `00` is the idle code. A controller that wants the register to keep its value must therefore drive `11`, not zero.

A synchronous active-high reset clears the register and takes priority over every mode. The register contents are the only output.

Top module: `quad_mode_shreg`

## Requirements
- R1: With mode `00`, the register takes the value of `par_in` at the rising clock edge.
- R2: With mode `01`, every bit moves one place toward the MSB at the rising edge, and bit 0 takes `ser_up`, so that `q` becomes `{q[W-2:0], ser_up}`.
- R3: With mode `10`, every bit moves one place toward the LSB at the rising edge, and bit W-1 takes `ser_dn`, so that `q` becomes `{ser_dn, q[W-1:1]}`.
- R4: With mode `11`, the register keeps its value, and `par_in`, `ser_up` and `ser_dn` have no effect on it.
- R5: When `rst` is high at a rising edge, `q` becomes all zeros whatever the mode. The reset is synchronous, so raising `rst` between edges leaves `q` unchanged until the next edge.
- R6: Exactly one operation happens per edge. Consecutive edges with different modes each apply their own operation to the result of the previous edge.
- R7: Shifting up discards the old MSB, and shifting down discards the old LSB. Neither end bit wraps around to the other end.
- R8: The width is the parameter `W` (default 4), and the behaviour of R1 to R7 is the same at any width of 2 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 2 | Operation select: 00 load, 01 up, 10 down, 11 hold |
| par_in | input | W | Parallel word captured in load mode |
| ser_up | input | 1 | Bit entering at the LSB during an up shift |
| ser_dn | input | 1 | Bit entering at the MSB during a down shift |
| q | output | W | Register contents |

## Verification
Every bit of the state is visible directly on `q`, and `q` is sampled one nanosecond after each edge. A wrong mode decode, a miswired neighbour link or a wrong end-bit source therefore shows on the port after the very edge that used it. The bench compares every edge with a reference model at two widths. A fault in the end-bit handling corrupts the bit that leaves or enters, so a fault at either end is caught on the first shift in that direction.

// File: rtl/qms_pkg.sv
package qms_pkg;

  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_KEEP = 2'b11
  } mode_e;

  typedef struct packed {
    logic load;
    logic up;
    logic down;
    logic keep;
  } op_sel_t;

  // Next value of one bit, given its own state and its two neighbours.
  function automatic logic cell_next(
    input op_sel_t s,
    input logic    cur,
    input logic    ld,
    input logic    from_lo,
    input logic    from_hi
  );
    logic r;
    r = 1'b0;
    if (s.load) r = r | ld;
    if (s.up)   r = r | from_lo;
    if (s.down) r = r | from_hi;
    if (s.keep) r = r | cur;
    return r;
  endfunction

endpackage

// File: rtl/qms_mode_dec.sv
module qms_mode_dec
  import qms_pkg::*;
(
  input  logic [1:0] mode,
  output op_sel_t    sel
);

  always_comb begin
    sel = '0;
    unique case (mode_e'(mode))
      MODE_LOAD: sel.load = 1'b1;
      MODE_UP:   sel.up   = 1'b1;
      MODE_DOWN: sel.down = 1'b1;
      MODE_KEEP: sel.keep = 1'b1;
      default:   sel.keep = 1'b1;
    endcase
  end

endmodule

// File: rtl/qms_bit_cell.sv
module qms_bit_cell
  import qms_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  op_sel_t sel,
  input  logic    ld,
  input  logic    from_lo,
  input  logic    from_hi,
  output logic    bit_q
);

  logic nxt;

  always_comb nxt = cell_next(sel, bit_q, ld, from_lo, from_hi);

  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= nxt;
  end

endmodule

// File: rtl/quad_mode_shreg.sv
module quad_mode_shreg
  import qms_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [W-1:0] par_in,
  input  logic         ser_up,
  input  logic         ser_dn,
  output logic [W-1:0] q
);

  localparam int MSB = W - 1;

  op_sel_t sel;
  // Named decode events, brought out for the checker.
  logic sel_load, sel_up, sel_down, sel_keep;

  qms_mode_dec u_dec (
    .mode (mode),
    .sel  (sel)
  );

  assign sel_load = sel.load;
  assign sel_up   = sel.up;
  assign sel_down = sel.down;
  assign sel_keep = sel.keep;

  // Neighbour links: the end cells take the serial inputs.
  logic [W-1:0] lo_link;
  logic [W-1:0] hi_link;

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i == 0) begin : g_lsb
      assign lo_link[i] = ser_up;
    end else begin : g_lo
      assign lo_link[i] = q[i-1];
    end
    if (i == MSB) begin : g_msb
      assign hi_link[i] = ser_dn;
    end else begin : g_hi
      assign hi_link[i] = q[i+1];
    end

    qms_bit_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .sel     (sel),
      .ld      (par_in[i]),
      .from_lo (lo_link[i]),
      .from_hi (hi_link[i]),
      .bit_q   (q[i])
    );
  end

endmodule

// File: rtl/quad_mode_shreg_chk.sv
module quad_mode_shreg_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic [W-1:0] par_in,
  input logic         ser_up,
  input logic         ser_dn,
  input logic [W-1:0] q,
  input logic         sel_load,
  input logic         sel_up,
  input logic         sel_down,
  input logic         sel_keep
);

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (q == $past(par_in)));  // R1

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (q == {$past(q[W-2:0]), $past(ser_up)}));  // R2

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (q == {$past(ser_dn), $past(q[W-1:1])}));  // R3

  AST_KEEP_VALUE: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> $stable(q));  // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (q == '0));  // R5

  AST_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    $onehot({sel_load, sel_up, sel_down, sel_keep}));  // R6

endmodule

bind quad_mode_shreg quad_mode_shreg_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .par_in   (par_in),
  .ser_up   (ser_up),
  .ser_dn   (ser_dn),
  .q        (q),
  .sel_load (sel_load),
  .sel_up   (sel_up),
  .sel_down (sel_down),
  .sel_keep (sel_keep)
);

// File: tb/quad_mode_shreg_tb.sv
module quad_mode_shreg_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b11;
  logic [6:0] par = '0;
  logic       su = 1'b0;
  logic       sd = 1'b0;
  logic [3:0] q;
  logic [6:0] q7;

  int n_run  = 0;
  int n_fail = 0;
  logic [15:0] m4, m7;

  always #2ns clk = ~clk;  // 250 MHz

  quad_mode_shreg #(.W(4)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .par_in(par[3:0]),
    .ser_up(su), .ser_dn(sd), .q(q)
  );

  quad_mode_shreg #(.W(7)) u_dut_w7 (
    .clk(clk), .rst(rst), .mode(mode), .par_in(par),
    .ser_up(su), .ser_dn(sd), .q(q7)
  );

  // Vector: {rst, mode[1:0], par[3:0], ser_up, ser_dn, expected q[3:0]}
  localparam int NV = 18;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 2'b00, 4'b1011, 1'b0, 1'b0, 4'b1011},
    {1'b0, 2'b01, 4'b0000, 1'b1, 1'b0, 4'b0111},
    {1'b0, 2'b01, 4'b1111, 1'b0, 1'b1, 4'b1110},
    {1'b0, 2'b10, 4'b0000, 1'b0, 1'b1, 4'b1111},
    {1'b0, 2'b10, 4'b1111, 1'b1, 1'b0, 4'b0111},
    {1'b0, 2'b11, 4'b0000, 1'b1, 1'b1, 4'b0111},
    {1'b0, 2'b00, 4'b0100, 1'b1, 1'b1, 4'b0100},
    {1'b0, 2'b10, 4'b1111, 1'b1, 1'b0, 4'b0010},
    {1'b0, 2'b01, 4'b0000, 1'b1, 1'b1, 4'b0101},
    {1'b0, 2'b11, 4'b1111, 1'b0, 1'b0, 4'b0101},
    {1'b1, 2'b00, 4'b1111, 1'b1, 1'b1, 4'b0000},
    {1'b0, 2'b01, 4'b0000, 1'b1, 1'b0, 4'b0001},
    {1'b0, 2'b01, 4'b1010, 1'b1, 1'b0, 4'b0011},
    {1'b0, 2'b01, 4'b0000, 1'b0, 1'b1, 4'b0110},
    {1'b0, 2'b01, 4'b0000, 1'b1, 1'b0, 4'b1101},
    {1'b0, 2'b10, 4'b0000, 1'b0, 1'b1, 4'b1110},
    {1'b0, 2'b00, 4'b1000, 1'b0, 1'b0, 4'b1000},
    {1'b1, 2'b11, 4'b0110, 1'b0, 1'b0, 4'b0000}
  };

  // Reference model: one edge applied to a value of width w.
  function automatic logic [15:0] model(input logic [15:0] cur, input int w,
                                        input logic r, input logic [1:0] md,
                                        input logic [15:0] p, input logic u,
                                        input logic d);
    logic [15:0] mask;
    mask = (16'h1 << w) - 16'h1;
    if (r) return 16'h0;
    case (md)
      2'b00:   return p & mask;
      2'b01:   return ((cur << 1) | 16'(u)) & mask;
      2'b10:   return (cur >> 1) | (16'(d) << (w - 1));
      default: return cur;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got,
                       input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Drive between edges, advance one edge, update models, sample after it.
  task automatic step(input logic r, input logic [1:0] md, input logic [6:0] p,
                      input logic u, input logic d);
    @(negedge clk);
    rst = r; mode = md; par = p; su = u; sd = d;
    @(posedge clk);
    m4 = model(m4, 4, r, md, 16'(p[3:0]), u, d);
    m7 = model(m7, 7, r, md, 16'(p), u, d);
    #1ns;
  endtask

  function automatic string mode_tag(input logic r, input logic [1:0] md);
    if (r) return "R5";
    case (md)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  bit done = 1'b0;

  initial begin
    m4 = '0; m7 = '0;
    step(1'b1, 2'b11, 7'h00, 1'b0, 1'b0);
    step(1'b1, 2'b00, 7'h7F, 1'b1, 1'b1);
    check("R5 reset state w4", 16'(q), 16'h0);
    check("R5 reset state w7 R8", 16'(q7), 16'h0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      step(v[12], v[11:10], {3'b101, v[9:6]}, v[5], v[4]);
      check(mode_tag(v[12], v[11:10]), 16'(q), 16'(v[3:0]));
      check("R8 width 7 vs model", 16'(q7), m7);
    end

    // R7: ends do not wrap
    step(1'b0, 2'b00, 7'b1000001, 1'b0, 1'b0);
    step(1'b0, 2'b01, 7'h00, 1'b0, 1'b0);
    check("R7 old MSB dropped on up shift", 16'(q), 16'b0010);
    check("R7 R8 up shift w7", 16'(q7), 16'b0000010);
    step(1'b0, 2'b00, 7'b1001001, 1'b0, 1'b0);
    step(1'b0, 2'b10, 7'h00, 1'b0, 1'b0);
    check("R7 old LSB dropped on down shift", 16'(q), 16'b0100);
    check("R7 R8 down shift w7", 16'(q7), 16'b0100100);

    // R6: alternating modes on consecutive edges
    step(1'b0, 2'b00, 7'b0000110, 1'b0, 1'b0);
    step(1'b0, 2'b01, 7'h7F, 1'b1, 1'b1);
    check("R6 load then up", 16'(q), 16'b1101);
    step(1'b0, 2'b10, 7'h7F, 1'b1, 1'b0);
    check("R6 up then down", 16'(q), 16'b0110);
    step(1'b0, 2'b11, 7'h00, 1'b0, 1'b1);
    check("R6 down then keep", 16'(q), 16'b0110);
    step(1'b0, 2'b01, 7'h00, 1'b0, 1'b1);
    check("R6 keep then up", 16'(q), 16'b1100);
    check("R6 R8 w7 vs model", 16'(q7), m7);

    // R4: hold while every other input toggles
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 2'b11, 7'(k * 37), k[0], ~k[0]);
      check("R4 keep ignores inputs", 16'(q), 16'b1100);
      check("R4 R8 keep w7", 16'(q7), m7);
    end

    // R5: reset is synchronous
    @(negedge clk);
    rst = 1'b1; mode = 2'b11;
    #1ns;
    check("R5 no clear before edge", 16'(q), 16'b1100);
    @(posedge clk);
    m4 = '0; m7 = '0;
    #1ns;
    check("R5 clear at edge", 16'(q), 16'h0);
    check("R5 R8 clear w7", 16'(q7), 16'h0);

    // R2 / R8: full serial fill upward
    for (int k = 0; k < 7; k++) begin
      step(1'b0, 2'b01, 7'h00, k[0] ^ k[1], 1'b0);
      check("R2 serial fill w4", 16'(q), m4);
      check("R2 R8 serial fill w7", 16'(q7), m7);
    end
    // R3 / R8: full serial fill downward
    for (int k = 0; k < 7; k++) begin
      step(1'b0, 2'b10, 7'h00, 1'b0, ~k[0]);
      check("R3 serial fill w4", 16'(q), m4);
      check("R3 R8 serial fill w7", 16'(q7), m7);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule